// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block turns word read requests from a CPU-side valid/ready port into read cycles on an external parallel ROM. It drives a 24-bit address, an active-low read strobe and an active-low chip select. It also drives a strobe that marks the state in which the 32-bit data bus is sampled. One chip-select region can be read in page mode. The first word of a page takes a full normal cycle of `n` states, where `n` comes from the `wait_n` input. Each later word of the same page takes a short beat of one to three states, and the strobes stay asserted across the whole burst.

A small control register holds the beat length and the page size. Writes to it take effect only while the bus is idle. A write made during a burst is held and applied once the burst is over. A sequential CPU keeps the burst going by presenting the next word address during the state in which the current word is captured. At every page boundary, and on any break in the sequence, the block returns to a full normal cycle.

Top module: `pmrom_read_ctrl`

## Requirements
- R1: After reset, `rom_rd_n` and `rom_cs_n` are high, `req_ready` is high and `rsp_valid` is low.
- R2: An access that is not a page hit holds `rom_rd_n` low for `wait_n` states, with `rom_cap` high in the last of them. `rsp_valid` pulses for one cycle in the next cycle, and `rsp_data` then equals the value on `rom_data` in the capture state.
- R3: A page hit lasts a number of states set by `cfg_wdata[1:0]`: 00 gives 1 state, 01 gives 2 and 10 gives 3.
- R4: The page size is set by `cfg_wdata[3:2]`: 00 gives 64 bytes (16 words), 01 gives 32, 10 gives 16 and 11 gives 8. The first word of every page, including a page reached by sequential reads, uses a normal cycle.
- R5: A request is a page hit only under all of these conditions. It is accepted in the capture state of a paged access. Its word address (`req_addr[23:2]`) is one more than that of the access being captured. It falls in the same page, and it targets the paged region. A non-sequential request starts a normal cycle.
- R6: Requests with `req_pg` low always use normal cycles, and `rom_cs_n` stays high for them.
- R7: If the beat code is 11, or if `wait_n` is less than the beat length plus one, every access uses a normal cycle.
- R8: Across back-to-back accesses that are accepted without a gap, `rom_rd_n` stays low and `rom_cs_n` keeps its region value. `rom_addr` shows the address of the access in progress.
- R9: `req_ready` is high only when idle and in the capture state. If no request is present in the capture state, the bus returns to idle.
- R10: A register write made while idle applies at once. A write made while an access is in progress is held, and takes effect only after the bus has gone idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 4 | [1:0] beat code, [3:2] page-size code |
| wait_n | input | 4 | Normal-cycle length in states (0 treated as 1) |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted at the next edge when high with valid |
| req_addr | input | 24 | Byte address of the requested word |
| req_pg | input | 1 | Request targets the page-mode region |
| rsp_valid | output | 1 | One-cycle pulse per returned word |
| rsp_data | output | 32 | Returned word |
| rom_addr | output | 24 | ROM address bus |
| rom_cs_n | output | 1 | Active-low chip select of the page-mode region |
| rom_rd_n | output | 1 | Active-low read strobe |
| rom_cap | output | 1 | High in the state whose closing edge samples the data bus |
| rom_data | input | 32 | ROM data bus |

## Verification
Several functions meet in the capture state of an access. The current word is sampled, the next request is accepted, and that request is classed as a page hit or a normal cycle, all in the same state. The bench holds `req_valid` high with the next address so that every word is accepted exactly in its predecessor's capture state. It sweeps all beat codes, all page sizes and `wait_n` values on both sides of the legal minimum, and judges each word by comparing its response cycle against the access lengths computed arithmetically. A second collision, a register write that lands in the middle of a burst, is judged by the old beat length holding to the end of that burst and the new one appearing in the next.

// File: rtl/pmrom_pkg.sv
package pmrom_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_NORM = 2'd1,
      ST_PAGE = 2'd2
   } bus_st_e;

   typedef struct packed {
      logic [1:0] pg_code;
      logic [1:0] beat_code;
   } pm_cfg_t;

   localparam logic [1:0] BEAT_RSVD = 2'b11;

endpackage

// File: rtl/pmrom_cfg.sv
module pmrom_cfg
   import pmrom_pkg::*;
#(
   parameter int         WAIT_W  = 4,
   parameter logic [3:0] RST_CFG = 4'b0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  pm_cfg_t           wr_cfg,
   input  logic              bus_idle,
   input  logic [WAIT_W-1:0] norm_len,
   output pm_cfg_t           cfg,
   output logic              page_ok,
   output logic [WAIT_W-1:0] beat_len
);

   generate
      if (WAIT_W < 3) begin : g_bad_wait_w
         $error("pmrom_cfg: WAIT_W must hold a count of at least 4");
      end
   endgenerate

   pm_cfg_t held_cfg;
   logic    held_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= pm_cfg_t'(RST_CFG);
         held_cfg <= pm_cfg_t'(RST_CFG);
         held_v   <= 1'b0;
      end else if (bus_idle) begin
         if (wr_en)       cfg <= wr_cfg;
         else if (held_v) cfg <= held_cfg;
         held_v <= 1'b0;
      end else if (wr_en) begin
         held_cfg <= wr_cfg;
         held_v   <= 1'b1;
      end
   end

   assign beat_len = WAIT_W'(cfg.beat_code) + WAIT_W'(1);
   assign page_ok  = (cfg.beat_code != BEAT_RSVD) && (norm_len > beat_len);

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_idle |=> $stable(cfg));

   // R10
   held_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_idle |=> !held_v);

endmodule

// File: rtl/pmrom_hit.sv
module pmrom_hit #(
   parameter int WA             = 22,
   parameter int PAGE_WORDS_MAX = 16
)(
   input  logic [WA-1:0] cur_w,
   input  logic [WA-1:0] nxt_w,
   input  logic [1:0]    pg_code,
   output logic          is_next,
   output logic          page_last
);

   generate
      if ((PAGE_WORDS_MAX >> 3) < 1 || (PAGE_WORDS_MAX & (PAGE_WORDS_MAX - 1)) != 0) begin : g_bad_page
         $error("pmrom_hit: largest page must be a power of two of at least 8 words");
      end
   endgenerate

   logic [WA-1:0] masks [4];

   generate
      for (genvar k = 0; k < 4; k++) begin : g_mask
         localparam int PW = PAGE_WORDS_MAX >> k;
         assign masks[k] = WA'(PW - 1);
      end
   endgenerate

   logic [WA-1:0] sel_mask;
   assign sel_mask  = masks[pg_code];
   assign is_next   = (nxt_w == cur_w + WA'(1));
   assign page_last = ((cur_w & sel_mask) == sel_mask);

endmodule

// File: rtl/pmrom_read_ctrl.sv
module pmrom_read_ctrl
   import pmrom_pkg::*;
#(
   parameter int         ADDR_W         = 24,
   parameter int         DATA_W         = 32,
   parameter int         WAIT_W         = 4,
   parameter int         PAGE_MAX_BYTES = 64,
   parameter logic [3:0] RST_CFG        = 4'b0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_wdata,
   input  logic [WAIT_W-1:0] wait_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_pg,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] rom_addr,
   output logic              rom_cs_n,
   output logic              rom_rd_n,
   output logic              rom_cap,
   input  logic [DATA_W-1:0] rom_data
);

   localparam int BYTES      = DATA_W / 8;
   localparam int BB         = $clog2(BYTES);
   localparam int WA         = ADDR_W - BB;
   localparam int PAGE_WORDS = PAGE_MAX_BYTES / BYTES;

   generate
      if (DATA_W % 8 != 0 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_data_w
         $error("pmrom_read_ctrl: DATA_W must be a power-of-two number of bytes");
      end
   endgenerate

   bus_st_e           st;
   logic [WAIT_W-1:0] cnt;
   logic [ADDR_W-1:0] addr_q;
   logic              cur_pg;

   pm_cfg_t           cfg;
   logic              page_ok;
   logic [WAIT_W-1:0] beat_len;
   logic [WAIT_W-1:0] norm_len;
   logic              is_next, page_last;
   logic              cap, accept, hit;

   assign norm_len = (wait_n == '0) ? WAIT_W'(1) : wait_n;

   pmrom_cfg #(.WAIT_W(WAIT_W), .RST_CFG(RST_CFG)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_cfg   (pm_cfg_t'(cfg_wdata)),
      .bus_idle (st == ST_IDLE),
      .norm_len (norm_len),
      .cfg      (cfg),
      .page_ok  (page_ok),
      .beat_len (beat_len)
   );

   pmrom_hit #(.WA(WA), .PAGE_WORDS_MAX(PAGE_WORDS)) u_hit (
      .cur_w     (addr_q[ADDR_W-1:BB]),
      .nxt_w     (req_addr[ADDR_W-1:BB]),
      .pg_code   (cfg.pg_code),
      .is_next   (is_next),
      .page_last (page_last)
   );

   assign cap       = (st != ST_IDLE) && (cnt == '0);
   assign req_ready = (st == ST_IDLE) || cap;
   assign accept    = req_valid && req_ready;
   assign hit       = cap && cur_pg && req_pg && page_ok && is_next && !page_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         addr_q    <= '0;
         cur_pg    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= cap;
         if (cap) rsp_data <= rom_data;
         if (accept) begin
            addr_q <= req_addr;
            cur_pg <= req_pg;
            if (hit) begin
               st  <= ST_PAGE;
               cnt <= beat_len - WAIT_W'(1);
            end else begin
               st  <= ST_NORM;
               cnt <= norm_len - WAIT_W'(1);
            end
         end else if (cap) begin
            st <= ST_IDLE;
         end else if (st != ST_IDLE) begin
            cnt <= cnt - WAIT_W'(1);
         end
      end
   end

   assign rom_addr = addr_q;
   assign rom_rd_n = (st == ST_IDLE);
   assign rom_cs_n = !((st != ST_IDLE) && cur_pg);
   assign rom_cap  = cap;

   // R2
   cap_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rom_cap |=> rsp_valid && rsp_data == $past(rom_data));

   // R6
   page_state_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PAGE) |-> !rom_cs_n);

   // R8
   cs_within_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_cs_n |-> !rom_rd_n);

   // R3
   beat_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PAGE) |-> cnt < WAIT_W'(3));

   // R9
   busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> $stable(rom_addr));

endmodule

// File: tb/pmrom_read_ctrl_bench.sv
module pmrom_read_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_wdata = 4'b0;
   logic [3:0]  wait_n = 4'd4;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_addr = 24'b0;
   logic        req_pg = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic [23:0] rom_addr;
   logic        rom_cs_n, rom_rd_n, rom_cap;
   logic [31:0] rom_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int beat_c = 0;
   int page_c = 0;

   logic [23:0] aa   [64];
   int          acc  [64];
   int          lenx [64];
   string       tagx [64];

   pmrom_read_ctrl u_pmrom_read_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .wait_n(wait_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_pg(req_pg), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rom_addr(rom_addr), .rom_cs_n(rom_cs_n),
      .rom_rd_n(rom_rd_n), .rom_cap(rom_cap), .rom_data(rom_data)
   );

   assign rom_data = {rom_addr[7:0] ^ 8'h3C, rom_addr};

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(input int c, input int p);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = {2'(p), 2'(c)};
      @(negedge clk);
      cfg_we = 1'b0;
      beat_c = c;
      page_c = p;
   endtask

   task automatic stream(input logic [23:0] base, input int k, input bit pg, input bit jump,
                         input int wr_at, input logic [3:0] wr_val, input string tag_ovr);
      int  i, r, it, gaps, bs, p, n;
      bit  ok, adv;
      bs = beat_c + 1;
      n  = int'(wait_n);
      ok = (beat_c != 3) && (n >= bs + 1);
      p  = 16 >> page_c;
      for (int j = 0; j < k; j++) begin
         aa[j] = base + 24'(4 * j) + ((jump && j >= k / 2) ? 24'd64 : 24'd0);
         if (j > 0 && pg && ok && (aa[j][23:2] == aa[j-1][23:2] + 22'd1)
             && ((int'(aa[j-1][23:2]) % p) != p - 1)) begin
            lenx[j] = bs;
            tagx[j] = "R3";
         end else begin
            lenx[j] = n;
            if (j == 0)                                   tagx[j] = "R2";
            else if (!pg)                                 tagx[j] = "R6";
            else if (!ok)                                 tagx[j] = "R7";
            else if (aa[j][23:2] != aa[j-1][23:2] + 22'd1) tagx[j] = "R5";
            else                                          tagx[j] = "R4";
         end
         if (tag_ovr != "") tagx[j] = tag_ovr;
      end
      i = 0; r = 0; it = 0; gaps = 0; adv = 1'b0;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = aa[0];
      req_pg    = pg;
      while (r < k) begin
         if (it > 0) @(negedge clk);
         if (it == wr_at) begin cfg_we = 1'b1; cfg_wdata = wr_val; end
         if (it == wr_at + 1) cfg_we = 1'b0;
         it++;
         if (adv) begin
            adv = 1'b0;
            if (i < k) req_addr = aa[i];
            else       req_valid = 1'b0;
         end
         if (rsp_valid && r < k) begin
            check(rsp_data == {aa[r][7:0] ^ 8'h3C, aa[r]}, "R2", "data", int'(rsp_data[23:0]), int'(aa[r]));
            check(cyc == acc[r] + lenx[r], tagx[r], "response cycle", cyc - acc[r], lenx[r]);
            r++;
         end
         if (i > 0 && r < k) begin
            if (rom_rd_n !== 1'b0 || rom_cs_n !== !pg || rom_addr !== aa[i-1]) gaps++;
         end
         if (i < k && req_ready) begin
            acc[i] = cyc + 1;
            i++;
            adv = 1'b1;
         end
      end
      check(gaps == 0, "R8", "strobe or address breaks in burst", gaps, 0);
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(rom_rd_n === 1'b1, "R1", "rd_n in reset", int'(rom_rd_n), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(rom_rd_n === 1'b1 && rom_cs_n === 1'b1, "R1", "strobes after reset", int'({rom_rd_n, rom_cs_n}), 3);
      check(req_ready === 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);

      // R9: single normal read, ready only in idle and capture state
      wait_n = 4'd4;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 24'h000100; req_pg = 1'b0;
      check(req_ready === 1'b1, "R9", "ready idle", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 0; t < 4; t++) begin
         check(req_ready === (t == 3), "R9", "ready during cycle", int'(req_ready), int'(t == 3));
         check(rom_cap === (t == 3), "R2", "capture strobe", int'(rom_cap), int'(t == 3));
         if (t < 3) @(negedge clk);
      end
      @(negedge clk);
      check(rsp_valid === 1'b1, "R2", "rsp after capture", int'(rsp_valid), 1);
      check(rom_rd_n === 1'b1, "R9", "idle after capture with no request", int'(rom_rd_n), 1);
      @(negedge clk);
      check(rsp_valid === 1'b0, "R2", "rsp single pulse", int'(rsp_valid), 0);

      // sweep beat codes, page codes and wait counts
      for (int c = 0; c < 4; c++) begin
         for (int p = 0; p < 4; p++) begin
            set_cfg(c, p);
            for (int w = 0; w < 3; w++) begin
               wait_n = (w == 2) ? 4'd6 : 4'(c + 1 + w);
               stream(24'h01000C, 2 * (16 >> p) + 3, 1'b1, 1'b0, -1, 4'b0, "");
            end
            wait_n = 4'd5;
            stream(24'h030004, 12, 1'b1, 1'b1, -1, 4'b0, "");
            stream(24'h040000, 6, 1'b0, 1'b0, -1, 4'b0, "");
         end
      end

      // R10: write held during a burst, applied after it
      set_cfg(0, 0);
      wait_n = 4'd4;
      stream(24'h020000, 10, 1'b1, 1'b0, 3, 4'b0010, "");
      beat_c = 2;
      stream(24'h020000, 10, 1'b1, 1'b0, -1, 4'b0, "R10");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule